// File: doc/BRIEF.md
# Sampling Converter Bus Control

This block is the digital front of a 12-bit parallel-output sampling converter. It watches an active-low chip select and a read/convert line and treats the two as one active-low command: when their OR falls while the converter is idle, a conversion begins. The block then holds a busy flag low for a fixed number of clocks and loads the result register. The conversion core here is a timed stand-in: it samples a 12-bit input word when the conversion starts and moves it into the result register at the end.

The result sits on a 16-line bus that is enabled only while chip select is low and read/convert is high. A byte-select input picks one of two line layouts. Results are 12-bit two's complement: 0x7FF is positive full scale, 0x000 is midscale, 0xFFF is one step below midscale and 0x800 is negative full scale. The block passes these codes through unchanged. Each result carries a flag that says whether the converter had time to acquire a fresh sample.

Top module: `adc_bus_ctl`

## Requirements
- R1: A conversion starts when the OR of `cs_n` and `rd_cnv`, after the two-flop synchronizer, goes from 1 to 0 while `busy` is high. Whichever of the two inputs goes low last triggers the start. With `cs_n` high, driving `rd_cnv` low starts nothing.
- R2: From the start, `busy` stays low for exactly CONV_CYCLES+1 clocks. The result register loads one clock before `busy` returns high.
- R3: A command edge that arrives while `busy` is low is ignored. The conversion length does not change, and no conversion follows if both inputs are high when `busy` rises.
- R4: `bus_oe` is 1 only when the synchronized `cs_n` is 0 and the synchronized `rd_cnv` is 1. It is 0 for every other combination.
- R5: If the command is still low when `busy` rises, `busy` stays high for one clock and a new conversion starts. The result of that conversion has `res_valid` = 0. A conversion started by a falling edge gives `res_valid` = 1.
- R6: With `byte_sel` = 0, line i (i = 0..7) carries result bit 11-i, line 8+j (j = 0..3) carries bit 3-j, and lines 12..15 are 0.
- R7: With `byte_sel` = 1, line j (j = 0..3) carries bit 3-j, lines 4..7 are 0, and line 8+i (i = 0..7) carries bit 11-i.
- R8: While a conversion runs, the enabled bus shows the previous result.
- R9: The sample word is captured in the clock that starts the conversion. Later changes on `sample_in` do not affect that result.
- R10: After reset `busy` = 1, `bus_oe` = 0, `res_valid` = 0 and the result register is 0.
- R11: The 12-bit code is reproduced unchanged, including 0x7FF, 0x800, 0xFFF and 0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_cnv | input | 1 | Read (high) / convert (low) control |
| byte_sel | input | 1 | Bus layout select |
| sample_in | input | 12 | Sample word taken by the stand-in core |
| busy | output | 1 | High when idle, low during a conversion |
| bus_out | output | 16 | Data lines; 0 when not enabled |
| bus_oe | output | 1 | Output enable of the data lines |
| res_valid | output | 1 | Held result came from a properly acquired sample |

## Verification
The bench holds the convert line low past the end of a conversion. A design that waits for a fresh edge would stay idle there, and one that does not flag the result would report it as valid. It pulses the convert line in the middle of a conversion: a design that re-arms would stretch `busy` or start a second conversion. It changes `sample_in` after the start and reads the bus during the conversion, which catches a design that samples late or loads the result early. Both byte layouts are checked against full-scale, midscale and mixed codes, so a swapped line or missing zero padding shows up as a wrong bus word.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } conv_st_e;
endpackage

// File: rtl/adc_ctl_sync.sv
module adc_ctl_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
    import adc_ctl_pkg::*;
#(
    parameter int DW          = 12,
    parameter int CONV_CYCLES = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_n,
    input  logic [DW-1:0] sample_i,
    output logic          busy_o,
    output logic          load_o,
    output logic [DW-1:0] load_data_o,
    output logic          load_ok_o
);
    localparam int CW = $clog2(CONV_CYCLES + 2);
    localparam logic [CW-1:0] CNT_TOP = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        conv_st_e      st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] hold;
        logic          ok;
        logic          after_done;
        logic          cmd_prev;
    } seq_t;

    seq_t sq_d, sq_q;
    logic fall;

    always_comb begin
        sq_d            = sq_q;
        sq_d.cmd_prev   = cmd_n;
        sq_d.after_done = 1'b0;
        load_o          = 1'b0;
        fall            = sq_q.cmd_prev & ~cmd_n;
        unique case (sq_q.st)
            ST_IDLE: begin
                if (fall || (sq_q.after_done && !cmd_n)) begin
                    sq_d.st   = ST_CONV;
                    sq_d.cnt  = CNT_TOP;
                    sq_d.hold = sample_i;
                    sq_d.ok   = fall;
                end
            end
            ST_CONV: begin
                if (sq_q.cnt == '0) begin
                    sq_d.st = ST_DONE;
                    load_o  = 1'b1;
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                sq_d.st         = ST_IDLE;
                sq_d.after_done = 1'b1;
            end
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: ST_IDLE, cnt: '0, hold: '0, ok: 1'b0,
                      after_done: 1'b0, cmd_prev: 1'b1};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o      = (sq_q.st == ST_IDLE);
    assign load_data_o = sq_q.hold;
    assign load_ok_o   = sq_q.ok;

    // checker-side count of consecutive busy-low clocks
    logic [CW:0] low_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_len_q <= '0;
        else if (!busy_o) low_len_q <= low_len_q + 1'b1;
        else              low_len_q <= '0;
    end

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (low_len_q <= (CW+1)'(CONV_CYCLES))); // R3
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (low_len_q == (CW+1)'(CONV_CYCLES + 1))); // R2
endmodule

// File: rtl/adc_ctl_bus.sv
module adc_ctl_bus #(
    parameter int DW = 12,
    parameter int BW = 16
) (
    input  logic          oe_en,
    input  logic          byte_sel,
    input  logic [DW-1:0] res,
    output logic [BW-1:0] bus_out
);
    localparam int HB = BW / 2;      // lines per half
    localparam int LB = DW - HB;     // low-order result bits

    logic [BW-1:0] lay_lo, lay_hi;

    for (genvar i = 0; i < HB; i++) begin : g_upper
        assign lay_lo[i]      = res[DW-1-i];
        assign lay_hi[HB + i] = res[DW-1-i];
    end
    for (genvar j = 0; j < HB; j++) begin : g_lower
        if (j < LB) begin : g_bit
            assign lay_lo[HB + j] = res[LB-1-j];
            assign lay_hi[j]      = res[LB-1-j];
        end else begin : g_pad
            assign lay_lo[HB + j] = 1'b0;
            assign lay_hi[j]      = 1'b0;
        end
    end

    assign bus_out = !oe_en ? '0 : (byte_sel ? lay_hi : lay_lo);
endmodule

// File: rtl/adc_bus_ctl.sv
module adc_bus_ctl #(
    parameter int DW          = 12,
    parameter int BW          = 16,
    parameter int CONV_CYCLES = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_cnv,
    input  logic          byte_sel,
    input  logic [DW-1:0] sample_in,
    output logic          busy,
    output logic [BW-1:0] bus_out,
    output logic          bus_oe,
    output logic          res_valid
);
    typedef struct packed {
        logic [DW-1:0] res;
        logic          ok;
    } res_t;

    logic [1:0]    ctl_s;
    logic          cs_s, rc_s, cmd_n;
    logic          load;
    logic          load_ok;
    logic [DW-1:0] load_data;
    res_t          rs_d, rs_q;

    adc_ctl_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, rd_cnv}),
        .dout (ctl_s)
    );

    assign cs_s  = ctl_s[1];
    assign rc_s  = ctl_s[0];
    assign cmd_n = cs_s | rc_s;

    adc_ctl_seq #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_n      (cmd_n),
        .sample_i   (sample_in),
        .busy_o     (busy),
        .load_o     (load),
        .load_data_o(load_data),
        .load_ok_o  (load_ok)
    );

    always_comb begin
        rs_d = rs_q;
        if (load) begin
            rs_d.res = load_data;
            rs_d.ok  = load_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '{res: '0, ok: 1'b0};
        else        rs_q <= rs_d;
    end

    assign bus_oe    = ~cs_s & rc_s;
    assign res_valid = rs_q.ok;

    adc_ctl_bus #(.DW(DW), .BW(BW)) u_bus (
        .oe_en   (bus_oe),
        .byte_sel(byte_sel),
        .res     (rs_q.res),
        .bus_out (bus_out)
    );

    AST_OE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!$past(cs_n, 2) && $past(rd_cnv, 2))); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rs_q.res) |-> $past(load)); // R8
    AST_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_valid) |-> $past(load)); // R5
endmodule

// File: tb/adc_bus_ctl_tb.sv
`timescale 1ns/1ps
module adc_bus_ctl_tb;
    localparam int CONV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_cnv = 1'b1;
    logic        byte_sel = 1'b0;
    logic [11:0] sample_in = '0;
    logic        busy, bus_oe, res_valid;
    logic [15:0] bus_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_bus_ctl #(.DW(12), .BW(16), .CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv),
        .byte_sel(byte_sel), .sample_in(sample_in), .busy(busy),
        .bus_out(bus_out), .bus_oe(bus_oe), .res_valid(res_valid)
    );

    typedef struct packed {
        logic [11:0] s;
        logic        b;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{s: 12'h7FF, b: 1'b0}, '{s: 12'h800, b: 1'b1},
        '{s: 12'hFFF, b: 1'b0}, '{s: 12'h000, b: 1'b1},
        '{s: 12'hA5C, b: 1'b0}, '{s: 12'h3C9, b: 1'b1}
    };

    function automatic logic [15:0] exp_bus(logic [11:0] r, logic b);
        logic [15:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            if (!b) v[i] = r[11-i]; else v[8+i] = r[11-i];
        end
        for (int j = 0; j < 4; j++) begin
            if (!b) v[8+j] = r[3-j]; else v[j] = r[3-j];
        end
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // cs_n is low on entry; rd_cnv pulses low to start
    task automatic convert(input logic [11:0] s, input bit hold_low, input bit glitch,
                           input bit chk_prev, input logic [11:0] prev, output int lowcnt);
        int w = 0;
        sample_in = s;
        rd_cnv = 1'b0;
        while (busy && w < 20) begin @(negedge clk); w++; end
        check("R1 start", busy, 1'b0);
        check("R4 oe off while convert low", bus_oe, 1'b0);
        sample_in = ~s;                        // R9 late change
        if (!hold_low) rd_cnv = 1'b1;
        lowcnt = 0;
        while (!busy && lowcnt < 1000) begin
            lowcnt++;
            if (glitch && lowcnt == 3) rd_cnv = 1'b0;
            if (glitch && lowcnt == 5) rd_cnv = 1'b1;
            if (chk_prev && lowcnt == 6)
                check("R8 previous result during conversion", bus_out, exp_bus(prev, byte_sel));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int lc;
        logic [11:0] prev;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R10 busy after reset", busy, 1'b1);
        check("R10 oe after reset", bus_oe, 1'b0);
        check("R10 valid after reset", res_valid, 1'b0);
        cs_n = 1'b0; rd_cnv = 1'b1;
        tick(3);
        check("R10 result zero", {bus_oe, bus_out}, {1'b1, 16'h0000});

        // table walk
        prev = 12'h000;
        for (int k = 0; k < 6; k++) begin
            byte_sel = VECS[k].b;
            convert(VECS[k].s, 1'b0, 1'b0, 1'b1, prev, lc);
            check("R2 busy low length", lc, CONV + 1);
            tick(3);
            check("R4 oe on for read", bus_oe, 1'b1);
            check("R6 R7 R9 R11 bus word", bus_out, exp_bus(VECS[k].s, VECS[k].b));
            check("R5 valid after edge start", res_valid, 1'b1);
            prev = VECS[k].s;
        end
        byte_sel = 1'b0;
        tick(1);
        check("R6 layout after byte flip", bus_out, exp_bus(prev, 1'b0));

        // R4 decode and R1 with cs_n last
        cs_n = 1'b1; rd_cnv = 1'b1;
        tick(3);
        check("R4 oe off cs high", bus_oe, 1'b0);
        rd_cnv = 1'b0;
        tick(5);
        check("R4 oe off cs high convert low", bus_oe, 1'b0);
        check("R1 no start while cs high", busy, 1'b1);
        sample_in = 12'h5A3;
        cs_n = 1'b0;
        lc = 0;
        while (busy && lc < 20) begin @(negedge clk); lc++; end
        check("R1 start with cs last", busy, 1'b0);
        rd_cnv = 1'b1;
        while (!busy && lc < 200) begin @(negedge clk); lc++; end
        tick(3);
        check("R1 result of cs-last start", bus_out, exp_bus(12'h5A3, 1'b0));

        // R3 glitch during conversion
        convert(12'h1E7, 1'b0, 1'b1, 1'b0, 12'h000, lc);
        check("R3 length unchanged by glitch", lc, CONV + 1);
        tick(6);
        check("R3 no extra conversion", busy, 1'b1);
        check("R3 result", bus_out, exp_bus(12'h1E7, 1'b0));

        // R5 back-to-back start while still low
        convert(12'h123, 1'b1, 1'b0, 1'b0, 12'h000, lc);
        check("R5 busy high after first", busy, 1'b1);
        check("R5 first result valid", res_valid, 1'b1);
        tick(1);
        check("R5 immediate restart", busy, 1'b0);
        rd_cnv = 1'b1;
        lc = 0;
        while (!busy && lc < 200) begin @(negedge clk); lc++; end
        tick(3);
        check("R5 restart flagged invalid", res_valid, 1'b0);
        convert(12'h456, 1'b0, 1'b0, 1'b0, 12'h000, lc);
        tick(3);
        check("R5 valid again after edge start", res_valid, 1'b1);
        check("R9 captured at start", bus_out, exp_bus(12'h456, 1'b0));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule